// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a cache and serves its miss requests. Each block miss from the cache is first compared against a one-entry stream buffer. On a match, the buffered block goes back to the cache one cycle later, the entry is emptied, and a fetch of the next sequential block is queued. If there is no match, the entry is emptied and the block is fetched from memory as a demand request. The stream then restarts at the block after the missed one. The block works the same way for instruction blocks and data blocks. It uses only block addresses, one memory port and one buffered block.

Prefetched blocks never go into the cache directly. They stay in the buffer until a later miss asks for them. Prefetches use the memory port only when it would otherwise be idle. A demand miss always takes the port ahead of a prefetch that is waiting to issue. The memory port has one request outstanding at a time, and responses come back in order. While a memory request is in flight or a demand miss is being served, the block holds off new misses with its ready output.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset, missReady is 1, rtnValid is 0 and memReqValid is 0. The buffer is empty, so the first miss always goes to memory.
- R2: A miss accepted while the buffer does not hold its address gives a memory request on the next cycle. That request carries the miss address with memReqPrefetch = 0 (0 marks a demand, 1 a prefetch).
- R3: The cycle after memRspValid answers a demand request, rtnValid is 1 for one cycle with rtnFromBuf = 0 (0 marks memory, 1 marks the buffer), the demand address and the response data.
- R4: Once the block is idle and no miss is presented, it issues a prefetch request (memReqPrefetch = 1) for the last accepted miss address plus one.
- R5: The response to a prefetch is stored in the buffer and produces no rtnValid pulse.
- R6: A miss whose address matches the valid buffer entry is answered on the cycle after acceptance with rtnFromBuf = 1 and the buffered data. No demand request is made for it, and the next prefetch targets its address plus one.
- R7: The buffer entry serves at most one hit and is discarded when any miss is accepted. A repeated or stale address is then fetched from memory.
- R8: A buffer miss restarts the stream. A prefetch that was queued but not yet issued is dropped, and the next prefetch is for the new miss address plus one.
- R9: When a miss arrives in the same cycle that a queued prefetch could issue, the demand request reaches memory first.
- R10: missReady stays 0 from a memory handshake until that request's response is handled. A demand request held off by memReqReady = 0 keeps memReqValid and memReqAddr stable.
- R11: Block addresses wrap, so a miss at the all-ones address prefetches address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Cache presents a block miss |
| missAddr | input | ADDR_W | Block address of the miss |
| missReady | output | 1 | Miss is accepted at this edge |
| rtnValid | output | 1 | Block returned to the cache |
| rtnAddr | output | ADDR_W | Address of the returned block |
| rtnData | output | BLOCK_BYTES*8 | Returned block contents |
| rtnFromBuf | output | 1 | 1 when served by the stream buffer |
| memReqValid | output | 1 | Memory request offered |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Requested block address |
| memReqPrefetch | output | 1 | 1 for prefetch, 0 for demand |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | BLOCK_BYTES*8 | Memory response block |

## Verification
The bench runs the block through several miss patterns:
- A unit-stride sweep. After the first miss, every request should hit in the buffer, one cycle after acceptance.
- A stride-two sweep. Every request should miss, and each miss should restart the stream.
- An immediate repeat of a just-hit address, which shows the entry serves only one hit.
- A miss at the all-ones address, which shows the address wraps.
- Back-to-back misses presented in the same cycle as each return, which shows demand requests go ahead of prefetches and that a queued prefetch is dropped.

The unit-stride and back-to-back patterns are also run with a longer memory latency and with a sparse ready signal. These runs show that misses stall while a request is in flight and that the order of requests still matches the expected sequence.

// File: rtl/stream_pf_pkg.sv
package stream_pf_pkg;

  typedef enum logic [1:0] {
    PF_IDLE,
    PF_DEM_REQ,
    PF_DEM_WAIT,
    PF_FILL_WAIT
  } pfState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeDemand;   // latch miss address as demand address
    logic armStream;    // next prefetch target = miss address + 1
    logic dropEntry;    // invalidate the buffer entry
    logic fillEntry;    // write prefetch response into the buffer
    logic retFromBuf;   // return buffered block next cycle
    logic retFromMem;   // return memory response next cycle
    logic selPrefetch;  // memory address mux selects prefetch target
  } pfStrobes_t;

endpackage

// File: rtl/stream_pf_ctrl.sv
module stream_pf_ctrl
  import stream_pf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       bufHit,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output logic       missReady,
  output logic       memReqValid,
  output logic       memReqPrefetch,
  output pfStrobes_t st
);

  pfState_e state, nextState;
  logic     pfPending;
  logic     accept;
  logic     pfIssue;

  assign missReady      = (state == PF_IDLE);
  assign accept         = missValid & missReady;
  assign pfIssue        = (state == PF_IDLE) & pfPending & ~missValid;
  assign memReqValid    = (state == PF_DEM_REQ) | pfIssue;
  assign memReqPrefetch = pfIssue;

  always_comb begin
    st             = '0;
    st.takeDemand  = accept & ~bufHit;
    st.armStream   = accept;
    st.dropEntry   = accept;
    st.fillEntry   = (state == PF_FILL_WAIT) & memRspValid;
    st.retFromBuf  = accept & bufHit;
    st.retFromMem  = (state == PF_DEM_WAIT) & memRspValid;
    st.selPrefetch = pfIssue;
  end

  always_comb begin
    nextState = state;
    case (state)
      PF_IDLE: begin
        if (accept && !bufHit)            nextState = PF_DEM_REQ;
        else if (pfIssue && memReqReady)  nextState = PF_FILL_WAIT;
      end
      PF_DEM_REQ:   if (memReqReady) nextState = PF_DEM_WAIT;
      PF_DEM_WAIT:  if (memRspValid) nextState = PF_IDLE;
      PF_FILL_WAIT: if (memRspValid) nextState = PF_IDLE;
      default:      nextState = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PF_IDLE;
      pfPending <= 1'b0;
    end else begin
      state <= nextState;
      if (accept)                      pfPending <= 1'b1;
      else if (pfIssue && memReqReady) pfPending <= 1'b0;
    end
  end

  // R10: a handshake closes the miss input until the response is handled
  assert_busy_blocks_miss_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !missReady);

  // R10: a stalled demand request stays offered as a demand
  assert_demand_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqPrefetch && !memReqReady) |=> (memReqValid && !memReqPrefetch));

endmodule

// File: rtl/stream_pf_datapath.sv
module stream_pf_datapath
  import stream_pf_pkg::*;
#(
  parameter int ADDR_W  = 27,
  parameter int BLOCK_W = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  pfStrobes_t         st,
  input  logic [ADDR_W-1:0]  missAddr,
  input  logic [BLOCK_W-1:0] memRspData,
  output logic               bufHit,
  output logic               bufValid,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic               rtnValid,
  output logic [ADDR_W-1:0]  rtnAddr,
  output logic [BLOCK_W-1:0] rtnData,
  output logic               rtnFromBuf
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0]  bufAddr;
  logic [BLOCK_W-1:0] bufData;
  logic [ADDR_W-1:0]  pfAddr;
  logic [ADDR_W-1:0]  demAddr;

  assign bufHit     = bufValid && (bufAddr == missAddr);
  assign memReqAddr = st.selPrefetch ? pfAddr : demAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid   <= 1'b0;
      bufAddr    <= '0;
      bufData    <= '0;
      pfAddr     <= '0;
      demAddr    <= '0;
      rtnValid   <= 1'b0;
      rtnAddr    <= '0;
      rtnData    <= '0;
      rtnFromBuf <= 1'b0;
    end else begin
      if (st.fillEntry) begin
        bufValid <= 1'b1;
        bufAddr  <= pfAddr;
        bufData  <= memRspData;
      end else if (st.dropEntry) begin
        bufValid <= 1'b0;
      end
      if (st.armStream)  pfAddr  <= missAddr + ADDR_ONE;
      if (st.takeDemand) demAddr <= missAddr;
      rtnValid <= st.retFromBuf | st.retFromMem;
      if (st.retFromBuf) begin
        rtnAddr    <= bufAddr;
        rtnData    <= bufData;
        rtnFromBuf <= 1'b1;
      end else if (st.retFromMem) begin
        rtnAddr    <= demAddr;
        rtnData    <= memRspData;
        rtnFromBuf <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
  import stream_pf_pkg::*;
#(
  parameter int ADDR_W      = 27,
  parameter int BLOCK_BYTES = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     missValid,
  input  logic [ADDR_W-1:0]        missAddr,
  output logic                     missReady,
  output logic                     rtnValid,
  output logic [ADDR_W-1:0]        rtnAddr,
  output logic [BLOCK_BYTES*8-1:0] rtnData,
  output logic                     rtnFromBuf,
  output logic                     memReqValid,
  input  logic                     memReqReady,
  output logic [ADDR_W-1:0]        memReqAddr,
  output logic                     memReqPrefetch,
  input  logic                     memRspValid,
  input  logic [BLOCK_BYTES*8-1:0] memRspData
);

  localparam int BLOCK_W = BLOCK_BYTES * 8;

  pfStrobes_t st;
  logic       bufHit;
  logic       bufValid;

  stream_pf_ctrl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .missValid      (missValid),
    .bufHit         (bufHit),
    .memReqReady    (memReqReady),
    .memRspValid    (memRspValid),
    .missReady      (missReady),
    .memReqValid    (memReqValid),
    .memReqPrefetch (memReqPrefetch),
    .st             (st)
  );

  stream_pf_datapath #(
    .ADDR_W  (ADDR_W),
    .BLOCK_W (BLOCK_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .missAddr   (missAddr),
    .memRspData (memRspData),
    .bufHit     (bufHit),
    .bufValid   (bufValid),
    .memReqAddr (memReqAddr),
    .rtnValid   (rtnValid),
    .rtnAddr    (rtnAddr),
    .rtnData    (rtnData),
    .rtnFromBuf (rtnFromBuf)
  );

  // R6: a buffer hit is answered on the following cycle from the buffer
  assert_hit_next_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady && bufHit) |=> (rtnValid && rtnFromBuf && rtnAddr == $past(missAddr)));

  // R7: any accepted miss leaves the entry empty
  assert_entry_one_shot_R7: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> !bufValid);

  // R2 and R9: a buffer miss is requested as a demand on the next cycle
  assert_miss_goes_demand_R2: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady && !bufHit) |=>
      (memReqValid && !memReqPrefetch && memReqAddr == $past(missAddr)));

  // R10: stalled demand address does not move
  assert_demand_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqPrefetch && !memReqReady) |=> $stable(memReqAddr));

endmodule

// File: tb/test_stream_prefetch_buf.sv
module test_stream_prefetch_buf;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 27;
  localparam int BB = 32;
  localparam int BW = BB * 8;

  logic          clk, rstN;
  logic          missValid, missReady;
  logic [AW-1:0] missAddr;
  logic          rtnValid, rtnFromBuf;
  logic [AW-1:0] rtnAddr;
  logic [BW-1:0] rtnData;
  logic          memReqValid, memReqReady, memReqPrefetch, memRspValid;
  logic [AW-1:0] memReqAddr;
  logic [BW-1:0] memRspData;

  stream_prefetch_buf #(.ADDR_W(AW), .BLOCK_BYTES(BB)) i_stream_prefetch_buf (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr), .missReady(missReady),
    .rtnValid(rtnValid), .rtnAddr(rtnAddr), .rtnData(rtnData), .rtnFromBuf(rtnFromBuf),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqPrefetch(memReqPrefetch), .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int checks = 0;
  int fails = 0;
  int memLat = 1;
  int readyMode = 0;
  int cyc = 0;
  int reqCount = 0;
  int rtnCount = 0;
  int rspCnt = 0;
  logic [AW-1:0] rspAddr;
  logic [AW-1:0] reqAddrLog [0:63];
  logic          reqPfLog   [0:63];

  function automatic logic [BW-1:0] blockOf(input logic [AW-1:0] a);
    logic [BW-1:0] r;
    for (int i = 0; i < BB / 4; i++) r[i*32 +: 32] = {a, i[2:0], 2'b01} ^ 32'h5A3C_96E1;
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Memory model: ready first, then response or handshake capture
  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    rspAddr     = '0;
    forever begin
      @(negedge clk);
      #2;
      memRspValid = 1'b0;
      memReqReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (!rstN) rspCnt = 0;
      else if (rspCnt > 0) begin
        rspCnt--;
        if (rspCnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = blockOf(rspAddr);
        end
      end else if (memReqValid && memReqReady) begin
        rspAddr = memReqAddr;
        rspCnt  = memLat;
        if (reqCount < 64) begin
          reqAddrLog[reqCount] = memReqAddr;
          reqPfLog[reqCount]   = memReqPrefetch;
        end
        reqCount++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    if (rtnValid) rtnCount++;
  end

  task automatic resetDut();
    rstN = 1'b0;
    missValid = 1'b0;
    missAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    reqCount = 0;
    rtnCount = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doMiss(input logic [AW-1:0] a, input bit immediate,
                        output int accWait, output int rtnWait);
    if (!immediate) @(negedge clk);
    missValid = 1'b1;
    missAddr  = a;
    accWait   = 0;
    while (!missReady && accWait < 500) begin
      @(negedge clk);
      accWait++;
    end
    rtnWait = 0;
    do begin
      @(negedge clk);
      rtnWait++;
      if (rtnWait == 1) missValid = 1'b0;
    end while (!rtnValid && rtnWait < 500);
  endtask

  task automatic missCheck(input logic [AW-1:0] a, input bit immediate, input bit expBuf,
                           input string req, output int accWait);
    int rw;
    doMiss(a, immediate, accWait, rw);
    check(req, "return valid", BW'(rtnValid), BW'(1));
    check(req, "return address", BW'(rtnAddr), BW'(a));
    check(req, "return data", rtnData, blockOf(a));
    check(req, "source flag", BW'(rtnFromBuf), BW'(expBuf));
    if (expBuf) check("R6", "hit latency", BW'(rw), BW'(1));
    else if (readyMode == 0) check("R3", "miss latency", BW'(rw), BW'(memLat + 2));
  endtask

  task automatic expectReq(input int idx, input logic [AW-1:0] a, input bit pf, input string req);
    check(req, "request address", BW'(reqAddrLog[idx]), BW'(a));
    check(req, "request kind", BW'(reqPfLog[idx]), BW'(pf));
  endtask

  initial begin
    int aw;
    logic [AW-1:0] base;
    rstN = 1'b0;
    missValid = 1'b0;
    missAddr = '0;

    // Unit stride, fast memory
    resetDut();
    check("R1", "missReady after reset", BW'(missReady), BW'(1));
    check("R1", "rtnValid after reset", BW'(rtnValid), BW'(0));
    check("R1", "memReqValid after reset", BW'(memReqValid), BW'(0));
    base = 27'h0000100;
    for (int i = 0; i < 12; i++) missCheck(base + AW'(i), 1'b0, i > 0, (i > 0) ? "R6" : "R1", aw);
    idle(10);
    check("R5", "returns equal misses", BW'(rtnCount), BW'(12));
    check("R4", "request count", BW'(reqCount), BW'(13));
    expectReq(0, base, 1'b0, "R2");
    for (int j = 1; j <= 12; j++) expectReq(j, base + AW'(j), 1'b1, "R4");

    // Stride two: each miss drops the entry and restarts the stream
    resetDut();
    base = 27'h2A000F0;
    for (int i = 0; i < 6; i++) missCheck(base + AW'(2 * i), 1'b0, 1'b0, "R8", aw);
    idle(6);
    check("R8", "stride request count", BW'(reqCount), BW'(12));
    for (int i = 0; i < 6; i++) begin
      expectReq(2 * i, base + AW'(2 * i), 1'b0, "R2");
      expectReq(2 * i + 1, base + AW'(2 * i + 1), 1'b1, "R8");
    end
    missCheck(base + AW'(1), 1'b0, 1'b0, "R7", aw);

    // One-shot entry
    resetDut();
    base = 27'h0123450;
    missCheck(base, 1'b0, 1'b0, "R2", aw);
    missCheck(base + AW'(1), 1'b0, 1'b1, "R6", aw);
    missCheck(base + AW'(1), 1'b0, 1'b0, "R7", aw);

    // Address wrap
    resetDut();
    base = '1;
    missCheck(base, 1'b0, 1'b0, "R11", aw);
    idle(6);
    expectReq(1, '0, 1'b1, "R11");
    missCheck('0, 1'b0, 1'b1, "R11", aw);

    // Demand priority and stream restart
    resetDut();
    missCheck(27'h0000400, 1'b0, 1'b0, "R9", aw);
    missCheck(27'h0000800, 1'b1, 1'b0, "R9", aw);
    idle(6);
    check("R9", "request count", BW'(reqCount), BW'(3));
    expectReq(0, 27'h0000400, 1'b0, "R9");
    expectReq(1, 27'h0000800, 1'b0, "R9");
    expectReq(2, 27'h0000801, 1'b1, "R8");
    missCheck(27'h0000801, 1'b0, 1'b1, "R8", aw);

    // Slow memory: misses stall behind an in-flight prefetch
    resetDut();
    memLat = 3;
    base = 27'h0050000;
    for (int i = 0; i < 6; i++) begin
      missCheck(base + AW'(i), 1'b0, i > 0, "R10", aw);
      if (i > 0) check("R10", "miss stalled by prefetch", BW'(aw >= 1), BW'(1));
    end

    // Sparse ready, back-to-back demands
    resetDut();
    readyMode = 1;
    memLat = 2;
    base = 27'h3000000;
    missCheck(base, 1'b0, 1'b0, "R10", aw);
    for (int i = 1; i < 6; i++) missCheck(base + AW'(3 * i), 1'b1, 1'b0, "R10", aw);
    idle(20);
    check("R10", "request count", BW'(reqCount), BW'(7));
    for (int i = 0; i < 6; i++) expectReq(i, base + AW'(3 * i), 1'b0, "R10");
    expectReq(6, base + AW'(16), 1'b1, "R8");
    check("R5", "returns equal misses", BW'(rtnCount), BW'(6));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule